// File: doc/BRIEF.md
# Paged Four-Channel UART Register Bank

This block is the byte-wide configuration store of a bridge that serves four serial channels. A host reaches it through a simple bus: an address, a channel index, a write strobe with write data, and a read strobe with read data. A few global registers sit at fixed addresses. They hold the per-channel clock enables, the soft-reset triggers next to read-only sleep status, and the GPIO direction and level bytes. Each channel also has a private set of registers. The channel index input picks the set. Within that set, a per-channel page bit decides whether offsets 0x04..0x06 reach the serial, line and FIFO controls or the baud-rate divisor.

The bank has no serial engines, FIFOs or interrupt logic. Its outputs drive clock enables, one-cycle reset pulses and the configuration fields of each channel. Read data is combinational and is gated by the read strobe. Reads of any unmapped address return zero.

Top module: `uart_regbank`

## Requirements
- R1: After asynchronous reset, every register is zero except the upper nibble of the global control register, which reads 1111. All outputs are zero, so address 0x00 reads 0xF0.
- R2: At address 0x00, bits 3..0 are read/write clock enables for channels 3..0 (bit n for channel n) and drive `ch_clk_en`. Writes to bits 7..4 have no effect, and those bits always read 1111.
- R3: A write to address 0x01 drives `ch_rst_pulse` high for exactly one cycle, on the channels whose bits 3..0 were written as 1. The pulse is visible in the cycle after the write. Reading 0x01 returns `ch_sleep` in bits 7..4 and zero in bits 3..0.
- R4: A soft reset returns the addressed channel's serial control, line, FIFO and baud registers to zero. It leaves that channel's page bit unchanged and does not affect other channels.
- R5: Address 0x21 (GPIO direction) and address 0x31 (GPIO level) are 8-bit read/write registers. They drive `gpio_dir` and `gpio_out`.
- R6: Channel offset 0x03 is the page register. Only bit 0 is stored, per channel, and it drives `ch_page`. Bits 7..1 read zero.
- R7: With the selected channel's page bit at 0, offsets 0x04, 0x05 and 0x06 reach the serial control, line configuration and FIFO control registers. These drive `ch_ctrl`, `ch_line` and `ch_fifo`, each channel n at slice n of the field width.
- R8: With the page bit at 1, offsets 0x04, 0x05 and 0x06 reach the divisor high byte, the divisor low byte and the fractional byte. These drive `ch_baud_div` ({high, low}, 16 bits per channel) and `ch_baud_frac`. The page-0 registers are left unchanged.
- R9: The serial control register stores only bits 2..0 (bit 0 receive, bit 1 transmit, bit 2 sleep enable). Bits 7..3 read zero.
- R10: Unmapped addresses (for example 0x02, 0x07, 0x3F) read zero, and writes to them change no register. `rd_data` is zero whenever `rd_en` is low.
- R11: Channel-register accesses affect only the channel selected by `ch_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Register address |
| ch_sel | input | 2 | Channel index for channel registers |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Combinational read data |
| ch_sleep | input | 4 | Sleep status per channel |
| ch_clk_en | output | 4 | Channel clock enables |
| ch_rst_pulse | output | 4 | One-cycle channel reset pulses |
| gpio_dir | output | 8 | GPIO direction |
| gpio_out | output | 8 | GPIO level |
| ch_page | output | 4 | Page bit per channel |
| ch_ctrl | output | 12 | Serial control, 3 bits per channel |
| ch_line | output | 32 | Line configuration, 8 bits per channel |
| ch_fifo | output | 32 | FIFO control, 8 bits per channel |
| ch_baud_div | output | 64 | Baud divisor, 16 bits per channel |
| ch_baud_frac | output | 32 | Baud fraction, 8 bits per channel |

## Verification
The bench builds the bank with its default 6-bit address (AW = 6). That covers all 64 addresses, so random traffic reaches every global register, every channel offset on both pages, and the unmapped holes between them. Random writes to 0x01 combine soft resets with page changes and configuration writes on all four channels. This exercises the rule that a reset spares the page bit, as well as the one-cycle pulse timing.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ch_sel,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic [3:0]    ch_sleep,
  output logic [3:0]    ch_clk_en,
  output logic [3:0]    ch_rst_pulse,
  output logic [7:0]    gpio_dir,
  output logic [7:0]    gpio_out,
  output logic [3:0]    ch_page,
  output logic [11:0]   ch_ctrl,
  output logic [31:0]   ch_line,
  output logic [31:0]   ch_fifo,
  output logic [63:0]   ch_baud_div,
  output logic [31:0]   ch_baud_frac
);
  localparam int NCH = 4;
  localparam logic [AW-1:0] A_GCTL = AW'('h00);
  localparam logic [AW-1:0] A_GRST = AW'('h01);
  localparam logic [AW-1:0] A_PAGE = AW'('h03);
  localparam logic [AW-1:0] A_OFS4 = AW'('h04);
  localparam logic [AW-1:0] A_OFS5 = AW'('h05);
  localparam logic [AW-1:0] A_OFS6 = AW'('h06);
  localparam logic [AW-1:0] A_GDIR = AW'('h21);
  localparam logic [AW-1:0] A_GDAT = AW'('h31);

  logic [2:0] scr_q  [NCH];
  logic [7:0] lcr_q  [NCH];
  logic [7:0] fcr_q  [NCH];
  logic [7:0] brh_q  [NCH];
  logic [7:0] brl_q  [NCH];
  logic [7:0] brd_q  [NCH];
  logic [NCH-1:0] page_q;
  logic [7:0] rd_val;

  wire soft_rst = wr_en && (addr == A_GRST);
  wire pg       = page_q[ch_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_clk_en    <= '0;
      ch_rst_pulse <= '0;
      gpio_dir     <= '0;
      gpio_out     <= '0;
      page_q       <= '0;
      for (int c = 0; c < NCH; c++) begin
        scr_q[c] <= '0; lcr_q[c] <= '0; fcr_q[c] <= '0;
        brh_q[c] <= '0; brl_q[c] <= '0; brd_q[c] <= '0;
      end
    end else begin
      ch_rst_pulse <= soft_rst ? wr_data[NCH-1:0] : '0;
      if (wr_en) begin
        case (addr)
          A_GCTL: ch_clk_en <= wr_data[NCH-1:0];
          A_GDIR: gpio_dir  <= wr_data;
          A_GDAT: gpio_out  <= wr_data;
          A_PAGE: page_q[ch_sel] <= wr_data[0];
          A_OFS4: if (pg) brh_q[ch_sel] <= wr_data; else scr_q[ch_sel] <= wr_data[2:0];
          A_OFS5: if (pg) brl_q[ch_sel] <= wr_data; else lcr_q[ch_sel] <= wr_data;
          A_OFS6: if (pg) brd_q[ch_sel] <= wr_data; else fcr_q[ch_sel] <= wr_data;
          default: ;
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        if (soft_rst && wr_data[c]) begin
          scr_q[c] <= '0; lcr_q[c] <= '0; fcr_q[c] <= '0;
          brh_q[c] <= '0; brl_q[c] <= '0; brd_q[c] <= '0;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_GCTL:  rd_val = {4'hF, ch_clk_en};
      A_GRST:  rd_val = {ch_sleep, 4'h0};
      A_GDIR:  rd_val = gpio_dir;
      A_GDAT:  rd_val = gpio_out;
      A_PAGE:  rd_val = {7'd0, pg};
      A_OFS4:  rd_val = pg ? brh_q[ch_sel] : {5'd0, scr_q[ch_sel]};
      A_OFS5:  rd_val = pg ? brl_q[ch_sel] : lcr_q[ch_sel];
      A_OFS6:  rd_val = pg ? brd_q[ch_sel] : fcr_q[ch_sel];
      default: rd_val = '0;
    endcase
  end

  assign rd_data = rd_en ? rd_val : 8'h00;
  assign ch_page = page_q;

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign ch_ctrl[c*3 +: 3]       = scr_q[c];
    assign ch_line[c*8 +: 8]       = lcr_q[c];
    assign ch_fifo[c*8 +: 8]       = fcr_q[c];
    assign ch_baud_div[c*16 +: 16] = {brh_q[c], brl_q[c]};
    assign ch_baud_frac[c*8 +: 8]  = brd_q[c];
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic [3:0]    ch_sleep,
  input logic [3:0]    ch_clk_en,
  input logic [3:0]    ch_rst_pulse,
  input logic [7:0]    gpio_dir
);
  wire grst_wr = wr_en && (addr == AW'('h01));

  assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grst_wr |=> ch_rst_pulse == $past(wr_data[3:0]));
  assert_rst_pulse_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !grst_wr |=> ch_rst_pulse == 4'h0);
  assert_grst_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('h01)) |-> rd_data == {ch_sleep, 4'h0});
  assert_ctl_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('h00)) |-> rd_data[7:4] == 4'hF);
  assert_clk_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h00)) |=> ch_clk_en == $past(wr_data[3:0]));
  assert_gpio_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h21)) |=> gpio_dir == $past(wr_data));
  assert_page_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('h03)) |-> rd_data[7:1] == 7'd0);
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'h00);
endmodule

bind uart_regbank uart_regbank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ch_sleep(ch_sleep), .ch_clk_en(ch_clk_en),
  .ch_rst_pulse(ch_rst_pulse), .gpio_dir(gpio_dir)
);

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] ch_sel = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] ch_sleep = '0;
  logic [3:0] ch_clk_en, ch_rst_pulse, ch_page;
  logic [7:0] gpio_dir, gpio_out;
  logic [11:0] ch_ctrl;
  logic [31:0] ch_line, ch_fifo, ch_baud_frac;
  logic [63:0] ch_baud_div;

  uart_regbank #(.AW(AW)) i_uart_regbank (.*);

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [3:0] m_en;
  logic [7:0] m_dir, m_dat;
  logic m_pg [4];
  logic [7:0] m_scr [4], m_lcr [4], m_fcr [4], m_brh [4], m_brl [4], m_brd [4];

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void m_reset();
    m_en = 0; m_dir = 0; m_dat = 0;
    for (int c = 0; c < 4; c++) begin
      m_pg[c] = 0; m_scr[c] = 0; m_lcr[c] = 0; m_fcr[c] = 0;
      m_brh[c] = 0; m_brl[c] = 0; m_brd[c] = 0;
    end
  endfunction

  function automatic void m_write(logic [AW-1:0] a, int c, logic [7:0] d);
    case (a)
      6'h00: m_en = d[3:0];
      6'h01: for (int k = 0; k < 4; k++) if (d[k]) begin
               m_scr[k] = 0; m_lcr[k] = 0; m_fcr[k] = 0;
               m_brh[k] = 0; m_brl[k] = 0; m_brd[k] = 0;
             end
      6'h03: m_pg[c] = d[0];
      6'h04: if (m_pg[c]) m_brh[c] = d; else m_scr[c] = {5'd0, d[2:0]};
      6'h05: if (m_pg[c]) m_brl[c] = d; else m_lcr[c] = d;
      6'h06: if (m_pg[c]) m_brd[c] = d; else m_fcr[c] = d;
      6'h21: m_dir = d;
      6'h31: m_dat = d;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [AW-1:0] a, int c, logic [3:0] slp);
    case (a)
      6'h00: return {4'hF, m_en};
      6'h01: return {slp, 4'h0};
      6'h03: return {7'd0, m_pg[c]};
      6'h04: return m_pg[c] ? m_brh[c] : m_scr[c];
      6'h05: return m_pg[c] ? m_brl[c] : m_lcr[c];
      6'h06: return m_pg[c] ? m_brd[c] : m_fcr[c];
      6'h21: return m_dir;
      6'h31: return m_dat;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_outputs(string req);
    chk({req, " clk_en"}, 64'(ch_clk_en), 64'(m_en));
    chk({req, " gpio"}, 64'({gpio_dir, gpio_out}), 64'({m_dir, m_dat}));
    for (int c = 0; c < 4; c++) begin
      chk({req, " R11 page"}, 64'(ch_page[c]), 64'(m_pg[c]));
      chk({req, " R7 ctrl"}, 64'({ch_ctrl[c*3 +: 3], ch_line[c*8 +: 8], ch_fifo[c*8 +: 8]}),
          64'({m_scr[c][2:0], m_lcr[c], m_fcr[c]}));
      chk({req, " R8 baud"}, 64'({ch_baud_div[c*16 +: 16], ch_baud_frac[c*8 +: 8]}),
          64'({m_brh[c], m_brl[c], m_brd[c]}));
    end
  endtask

  task automatic wr(logic [AW-1:0] a, int c, logic [7:0] d);
    @(negedge clk);
    addr = a; ch_sel = 2'(c); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    m_write(a, c, d);
    if (a == 6'h01) begin
      chk("R3 pulse", 64'(ch_rst_pulse), 64'(d[3:0]));
      @(negedge clk);
      chk("R3 pulse end", 64'(ch_rst_pulse), 64'h0);
    end else begin
      chk("R3 no pulse", 64'(ch_rst_pulse), 64'h0);
    end
  endtask

  task automatic rd(string req, logic [AW-1:0] a, int c);
    @(negedge clk);
    addr = a; ch_sel = 2'(c); rd_en = 1;
    #2;
    chk(req, 64'(rd_data), 64'(m_read(a, c, ch_sleep)));
    rd_en = 0;
    #1;
    chk("R10 idle read", 64'(rd_data), 64'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] pool [10];
    void'($urandom(32'd2718));
    pool = '{6'h00, 6'h01, 6'h03, 6'h04, 6'h05, 6'h06, 6'h21, 6'h31, 6'h02, 6'h3F};
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_outputs("R1 reset");
    rd("R1 ctl reset", 6'h00, 0);
    chk("R1 ctl value", 64'(m_read(6'h00, 0, 4'h0)), 64'hF0);

    wr(6'h00, 0, 8'h0A);
    rd("R2 upper ignored", 6'h00, 0);
    check_outputs("R2");
    ch_sleep = 4'b1010;
    rd("R3 sleep read", 6'h01, 0);
    wr(6'h21, 0, 8'h5C); wr(6'h31, 0, 8'hA3);
    rd("R5 dir", 6'h21, 0); rd("R5 dat", 6'h31, 0);

    wr(6'h04, 2, 8'hFF);
    rd("R9 scr reserved", 6'h04, 2);
    wr(6'h05, 2, 8'h3B); wr(6'h06, 2, 8'hC4);
    wr(6'h03, 2, 8'hFF);
    rd("R6 page bits", 6'h03, 2);
    wr(6'h04, 2, 8'h12); wr(6'h05, 2, 8'h34); wr(6'h06, 2, 8'h56);
    rd("R8 brh", 6'h04, 2); rd("R8 brl", 6'h05, 2); rd("R8 brd", 6'h06, 2);
    check_outputs("R8 page1 keeps page0");
    wr(6'h03, 2, 8'h00);
    rd("R7 scr", 6'h04, 2); rd("R7 lcr", 6'h05, 2); rd("R7 fcr", 6'h06, 2);
    rd("R11 other ch", 6'h05, 1);

    wr(6'h03, 2, 8'h01);
    wr(6'h01, 0, 8'h04);
    check_outputs("R4 soft reset keeps page");
    rd("R4 page kept", 6'h03, 2);

    wr(6'h02, 0, 8'hFF); wr(6'h3F, 1, 8'hFF);
    rd("R10 unmapped 02", 6'h02, 0); rd("R10 unmapped 3F", 6'h3F, 1);
    check_outputs("R10 unmapped write");

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      int c;
      logic [7:0] d;
      a = pool[$urandom_range(0, 9)];
      if ($urandom_range(0, 7) == 0) a = AW'($urandom);
      c = $urandom_range(0, 3);
      d = 8'($urandom);
      ch_sleep = 4'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr(a, c, d);
        check_outputs("R11 random write");
      end else begin
        rd("R7 random read", a, c);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule